// File: doc/BRIEF.md
# Programmable Occupancy Threshold Flag Unit

This block sits next to a FIFO and tracks how many words it holds, using the FIFO's accepted write and read events. From that count it drives two threshold flags. The almost-empty flag warns that few words remain to read. The almost-full flag warns that little room remains to write. Each threshold comes from its own offset register. The FIFO storage is not part of this block.

On master reset both offsets take a preset value picked by a 3-bit select input. Software or board logic can then reprogram them in either of two ways. The first is a parallel load strobe with a data bus. The second is a slow bit-serial link with its own clock, enable and data lines. That link is oversampled and edge-detected in the block clock domain.

A mode input picks when the flags react. In one mode they follow the count straight away through combinational logic. In the other they pass through a register stage on the port clock. A partial reset empties the count but keeps the programmed offsets.

Top module: `pflag_unit`

## Requirements
- R1: A clock edge with `mrst_n` low loads both offsets with the preset min(2^(sel+1)-1, DEPTH-1), where sel is `preset_sel` (sel=0 gives 1, sel=3 gives 15, sel=7 gives 255 when DEPTH=256). The same edge clears the occupancy. After that edge `almost_empty` is 1 and `almost_full` is 0.
- R2: The occupancy rises by one on a cycle with `wr_ev` high and `rd_ev` low, unless it already equals DEPTH. It falls by one on a cycle with `rd_ev` high and `wr_ev` low, unless it is 0. When both are high, the count is unchanged if it is strictly between 0 and DEPTH. At 0 only the write counts, and at DEPTH only the read counts. The count never leaves the range 0..DEPTH.
- R3: `almost_empty` is 1 exactly when occupancy <= the empty offset.
- R4: `almost_full` is 1 exactly when (DEPTH - occupancy) <= the full offset.
- R5: With `flag_async` = 1, both flags reflect the count immediately after the edge that changes it. With `flag_async` = 0, they reflect it one clock later.
- R6: Each cycle with `ld_stb` high writes `ld_data` into the next offset register. The order is empty offset, then full offset, then empty again. After either reset the next target is the empty offset.
- R7: Each rising edge of `ser_clk` seen with `ser_en` high stores `ser_din` as the next offset bit, LSB first. The first OW bits (OW = log2(DEPTH)) fill the empty offset and the next OW bits fill the full offset. Bits after the 2*OW-th are dropped.
- R8: Rising edges of `ser_clk` while `ser_en` is low change no offset bit and do not advance the bit position.
- R9: A cycle with `prst_n` low (and `mrst_n` high) clears the occupancy, keeps both offsets, and ignores `ld_stb` and serial bits. It also restarts both the load order and the serial bit position.
- R10: A later master reset discards programmed offsets and loads the presets for the current `preset_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock for counting, loading and synchronous flags |
| mrst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| wr_ev | input | 1 | A word was written into the FIFO this cycle |
| rd_ev | input | 1 | A word was read from the FIFO this cycle |
| ld_stb | input | 1 | Parallel offset load strobe |
| ld_data | input | OW | Parallel offset value |
| ser_clk | input | 1 | Serial programming clock (slow, oversampled) |
| ser_en | input | 1 | Serial enable |
| ser_din | input | 1 | Serial data bit |
| preset_sel | input | 3 | Preset offset select, used during master reset |
| flag_async | input | 1 | 1: combinational flags, 0: registered flags |
| almost_empty | output | 1 | Programmable almost-empty flag |
| almost_full | output | 1 | Programmable almost-full flag |

## Verification
Several properties are checked on every clock. The count stays within 0..DEPTH and steps correctly on writes, reads and refused events. Offsets load their presets after master reset and survive partial reset. The load order alternates. The serial position halts at its end. The flags are set at a completely empty or completely full FIFO. In synchronous mode the flags trail the count by one cycle. Other behaviour can only be seen through the bench's scenarios, which recover each offset value by filling the FIFO from empty. These cover the exact thresholds after parallel and serial programming, LSB-first bit order, dropped serial bits, simultaneous events at the range ends, and the preset values for different select codes.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

   localparam int unsigned PRESET_COUNT = 8;
   localparam int unsigned PRESET_SEL_W = 3;

   // preset offset for select code k: 2^(k+1)-1, clipped to depth-1
   function automatic int unsigned preset_offset(input int unsigned depth,
                                                 input int unsigned k);
      int unsigned v;
      v = (32'd2 << k) - 32'd1;
      return (v > depth - 1) ? depth - 1 : v;
   endfunction

endpackage

// File: rtl/pflag_occ_count.sv
module pflag_occ_count #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          wr_ev,
   input  logic          rd_ev,
   output logic [CW-1:0] occ,
   output logic [CW-1:0] free
);

   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   logic do_wr, do_rd;

   always_comb begin
      do_wr = wr_ev && (occ != FULL_LVL);
      do_rd = rd_ev && (occ != '0);
   end

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) begin
         occ <= '0;
      end else begin
         case ({do_wr, do_rd})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign free = FULL_LVL - occ;

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      occ <= FULL_LVL);

   p_write_step_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && wr_ev && !rd_ev && occ != FULL_LVL) |=> occ == $past(occ) + 1'b1);

   p_empty_read_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && rd_ev && !wr_ev && occ == '0) |=> occ == '0);

   p_full_write_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && wr_ev && !rd_ev && occ == FULL_LVL) |=> occ == FULL_LVL);

   p_both_mid_r2: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && wr_ev && rd_ev && occ != '0 && occ != FULL_LVL) |=> $stable(occ));

   p_prst_clear_r9: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> occ == '0);

endmodule

// File: rtl/pflag_ser_sync.sv
module pflag_ser_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic mrst_n,
   input  logic ser_clk,
   input  logic ser_en,
   input  logic ser_din,
   output logic bit_step,
   output logic bit_val
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pflag_ser_sync: STAGES must be at least 2");
   end

   // lanes: [0] serial clock, [1] enable, [2] data
   logic [2:0] chain [STAGES];
   logic       clk_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!mrst_n) chain[0] <= '0;
            else         chain[0] <= {ser_din, ser_en, ser_clk};
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!mrst_n) chain[s] <= '0;
            else         chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!mrst_n) clk_prev <= 1'b0;
      else         clk_prev <= chain[STAGES-1][0];
   end

   assign bit_step = chain[STAGES-1][0] && !clk_prev && chain[STAGES-1][1];
   assign bit_val  = chain[STAGES-1][2];

   p_step_single_r7: assert property (@(posedge clk) disable iff (!mrst_n)
      bit_step |=> !bit_step);

endmodule

// File: rtl/pflag_offset_regs.sv
module pflag_offset_regs
   import pflag_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned OW = $clog2(DEPTH),
   localparam int unsigned NBITS = 2 * OW,
   localparam int unsigned IW = $clog2(NBITS + 1)
) (
   input  logic                    clk,
   input  logic                    mrst_n,
   input  logic                    prst_n,
   input  logic [PRESET_SEL_W-1:0] preset_sel,
   input  logic                    ld_stb,
   input  logic [OW-1:0]           ld_data,
   input  logic                    bit_step,
   input  logic                    bit_val,
   output logic [OW-1:0]           ae_off,
   output logic [OW-1:0]           af_off
);

   localparam logic [IW-1:0] IDX_END = IW'(NBITS);

   logic [OW-1:0] preset_tbl [PRESET_COUNT];

   for (genvar k = 0; k < PRESET_COUNT; k++) begin : g_preset
      assign preset_tbl[k] = OW'(preset_offset(DEPTH, k));
   end

   logic          ld_to_full;   // 0: next parallel load targets empty offset
   logic [IW-1:0] bit_idx;
   logic [OW-1:0] ae_nx, af_nx;
   logic [IW-1:0] idx_nx;
   logic          ptr_nx;

   always_comb begin
      ae_nx  = ae_off;
      af_nx  = af_off;
      idx_nx = bit_idx;
      ptr_nx = ld_to_full;
      if (bit_step && bit_idx != IDX_END) begin
         for (int b = 0; b < OW; b++) begin
            if (bit_idx == IW'(b))      ae_nx[b] = bit_val;
            if (bit_idx == IW'(b + OW)) af_nx[b] = bit_val;
         end
         idx_nx = bit_idx + 1'b1;
      end
      if (ld_stb) begin
         if (ld_to_full) af_nx = ld_data;
         else            ae_nx = ld_data;
         ptr_nx = !ld_to_full;
      end
   end

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         ae_off     <= preset_tbl[preset_sel];
         af_off     <= preset_tbl[preset_sel];
         ld_to_full <= 1'b0;
         bit_idx    <= '0;
      end else if (!prst_n) begin
         ld_to_full <= 1'b0;
         bit_idx    <= '0;
      end else begin
         ae_off     <= ae_nx;
         af_off     <= af_nx;
         ld_to_full <= ptr_nx;
         bit_idx    <= idx_nx;
      end
   end

   p_preset_load_r1: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(mrst_n) |-> (ae_off == preset_tbl[$past(preset_sel)]
                         && af_off == preset_tbl[$past(preset_sel)]));

   p_ptr_toggle_r6: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && ld_stb) |=> ld_to_full != $past(ld_to_full));

   p_ser_stop_r7: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && bit_idx == IDX_END) |=> bit_idx == IDX_END);

   p_prst_keep_r9: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> ($stable(ae_off) && $stable(af_off)));

   p_idle_keep_r8: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && !bit_step && !ld_stb) |=> ($stable(ae_off) && $stable(af_off)));

endmodule

// File: rtl/pflag_cell.sv
module pflag_cell #(
   parameter int unsigned CW = 9,
   parameter int unsigned OW = 8,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic          clk,
   input  logic          mrst_n,
   input  logic          prst_n,
   input  logic          async_mode,
   input  logic [CW-1:0] level,
   input  logic [OW-1:0] offset,
   output logic          flag
);

   if (OW >= CW) begin : g_bad_width
      $error("pflag_cell: offset must be narrower than level");
   end

   logic raw, held;

   assign raw = level <= CW'(offset);

   always_ff @(posedge clk) begin
      if (!mrst_n || !prst_n) held <= RST_VAL;
      else                    held <= raw;
   end

   assign flag = async_mode ? raw : held;

endmodule

// File: rtl/pflag_unit.sv
module pflag_unit
   import pflag_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned SER_STAGES = 2,
   localparam int unsigned OW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    mrst_n,
   input  logic                    prst_n,
   input  logic                    wr_ev,
   input  logic                    rd_ev,
   input  logic                    ld_stb,
   input  logic [OW-1:0]           ld_data,
   input  logic                    ser_clk,
   input  logic                    ser_en,
   input  logic                    ser_din,
   input  logic [PRESET_SEL_W-1:0] preset_sel,
   input  logic                    flag_async,
   output logic                    almost_empty,
   output logic                    almost_full
);

   if (DEPTH < 4) begin : g_bad_depth
      $error("pflag_unit: DEPTH must be at least 4");
   end
   if ((1 << OW) != DEPTH) begin : g_bad_pow2
      $error("pflag_unit: DEPTH must be a power of two");
   end

   logic [CW-1:0] occ, free;
   logic [OW-1:0] ae_off, af_off;
   logic          bit_step, bit_val;
   logic          ld_ok, step_ok;

   // partial reset blocks programming in the same cycle
   assign ld_ok   = ld_stb && prst_n;
   assign step_ok = bit_step && prst_n;

   pflag_occ_count #(.DEPTH(DEPTH)) u_count (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .wr_ev(wr_ev), .rd_ev(rd_ev), .occ(occ), .free(free)
   );

   pflag_ser_sync #(.STAGES(SER_STAGES)) u_ser (
      .clk(clk), .mrst_n(mrst_n), .ser_clk(ser_clk), .ser_en(ser_en),
      .ser_din(ser_din), .bit_step(bit_step), .bit_val(bit_val)
   );

   pflag_offset_regs #(.DEPTH(DEPTH)) u_offs (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .preset_sel(preset_sel),
      .ld_stb(ld_ok), .ld_data(ld_data), .bit_step(step_ok), .bit_val(bit_val),
      .ae_off(ae_off), .af_off(af_off)
   );

   // channel 0: almost-empty on occupancy; channel 1: almost-full on free space
   logic [CW-1:0] ch_level  [2];
   logic [OW-1:0] ch_offset [2];
   logic [1:0]    ch_flag;

   assign ch_level[0]  = occ;
   assign ch_level[1]  = free;
   assign ch_offset[0] = ae_off;
   assign ch_offset[1] = af_off;

   for (genvar c = 0; c < 2; c++) begin : g_flag
      pflag_cell #(.CW(CW), .OW(OW), .RST_VAL(c == 0)) u_cell (
         .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .async_mode(flag_async),
         .level(ch_level[c]), .offset(ch_offset[c]), .flag(ch_flag[c])
      );
   end

   assign almost_empty = ch_flag[0];
   assign almost_full  = ch_flag[1];

   p_empty_flag_r3: assert property (@(posedge clk) disable iff (!mrst_n)
      (flag_async && occ == '0) |-> almost_empty);

   p_full_flag_r4: assert property (@(posedge clk) disable iff (!mrst_n)
      (flag_async && occ == CW'(DEPTH)) |-> almost_full);

   p_sync_lag_r5: assert property (@(posedge clk) disable iff (!mrst_n)
      (!flag_async && prst_n) |=>
         (!flag_async -> (almost_empty == ($past(occ) <= CW'($past(ae_off)))
                          && almost_full == ($past(free) <= CW'($past(af_off))))));

endmodule

// File: tb/pflag_unit_test.sv
module pflag_unit_test;

   localparam int DEPTH = 256;
   localparam int OW = 8;

   logic          clk = 1'b0;
   logic          mrst_n = 1'b0;
   logic          prst_n = 1'b1;
   logic          wr_ev = 1'b0, rd_ev = 1'b0, ld_stb = 1'b0;
   logic [OW-1:0] ld_data = '0;
   logic          ser_clk = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
   logic [2:0]    preset_sel = 3'd3;
   logic          flag_async = 1'b1;
   logic          almost_empty, almost_full;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pflag_unit #(.DEPTH(DEPTH)) uut (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .wr_ev(wr_ev), .rd_ev(rd_ev),
      .ld_stb(ld_stb), .ld_data(ld_data), .ser_clk(ser_clk), .ser_en(ser_en),
      .ser_din(ser_din), .preset_sel(preset_sel), .flag_async(flag_async),
      .almost_empty(almost_empty), .almost_full(almost_full)
   );

   task automatic check(input string req, input int actual, input int expected);
      total++;
      if (actual != expected) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   task automatic cycle(input logic w, input logic r);
      @(negedge clk);
      wr_ev = w; rd_ev = r;
      @(negedge clk);
      wr_ev = 1'b0; rd_ev = 1'b0;
   endtask

   task automatic do_mrst(input logic [2:0] sel);
      @(negedge clk);
      preset_sel = sel; mrst_n = 1'b0;
      @(negedge clk);
      mrst_n = 1'b1;
   endtask

   task automatic do_prst();
      @(negedge clk);
      prst_n = 1'b0;
      @(negedge clk);
      prst_n = 1'b1;
   endtask

   task automatic par_load(input int v);
      @(negedge clk);
      ld_stb = 1'b1; ld_data = OW'(v);
      @(negedge clk);
      ld_stb = 1'b0;
   endtask

   task automatic ser_bit(input logic en, input logic b);
      @(negedge clk);
      ser_en = en; ser_din = b;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      ser_en = 1'b0;
   endtask

   // empties the count, fills it word by word, infers both offsets from the flags
   task automatic measure(output int ae_off, output int af_off);
      int ae_fall = -1, af_rise = -1;
      do_prst();
      flag_async = 1'b1;
      for (int n = 1; n <= DEPTH; n++) begin
         cycle(1'b1, 1'b0);
         if (ae_fall < 0 && !almost_empty) ae_fall = n;
         if (af_rise < 0 && almost_full)  af_rise = n;
      end
      ae_off = ae_fall - 1;
      af_off = DEPTH - af_rise;
   endtask

   task automatic t_reset();
      int ae, af;
      do_mrst(3'd3);
      check("R1 reset almost_empty", almost_empty, 1);
      check("R1 reset almost_full", almost_full, 0);
      measure(ae, af);
      check("R1 preset sel3 empty offset", ae, 15);
      check("R1 preset sel3 full offset", af, 15);
   endtask

   task automatic t_count();
      // FIFO full from measure: extra writes refused (R2)
      repeat (5) cycle(1'b1, 1'b0);
      for (int n = 0; n < 15; n++) cycle(1'b0, 1'b1);
      check("R4 free=15 raises almost_full", almost_full, 1);
      cycle(1'b0, 1'b1);
      check("R2 R4 overflow refused, free=16 drops almost_full", almost_full, 0);
      // read to empty then extra reads
      for (int n = 0; n < DEPTH - 16; n++) cycle(1'b0, 1'b1);
      check("R3 empty almost_empty", almost_empty, 1);
      repeat (4) cycle(1'b0, 1'b1);
      cycle(1'b1, 1'b1);   // at 0: write counts only -> 1
      for (int n = 0; n < 9; n++) cycle(1'b1, 1'b0);   // 10
      repeat (5) cycle(1'b1, 1'b1);                    // unchanged
      for (int n = 0; n < 5; n++) cycle(1'b1, 1'b0);   // 15
      check("R3 occupancy 15 almost_empty", almost_empty, 1);
      cycle(1'b1, 1'b0);                               // 16
      check("R2 R3 occupancy 16 clears almost_empty", almost_empty, 0);
   endtask

   task automatic t_sync_mode();
      do_prst();
      flag_async = 1'b0;
      for (int n = 0; n < 16; n++) cycle(1'b1, 1'b0);  // occ 16
      @(negedge clk);
      check("R5 sync flag after settle", almost_empty, 0);
      cycle(1'b0, 1'b1);                               // occ 15, flag lags
      check("R5 sync flag one cycle late", almost_empty, 0);
      @(negedge clk);
      check("R5 sync flag follows next cycle", almost_empty, 1);
      flag_async = 1'b1;
      cycle(1'b1, 1'b0);
      check("R5 async flag same cycle", almost_empty, 0);
   endtask

   task automatic t_parallel();
      int ae, af;
      do_prst();
      par_load(5);
      par_load(200);
      measure(ae, af);
      check("R6 parallel empty offset", ae, 5);
      check("R6 parallel full offset", af, 200);
      par_load(40);
      par_load(90);
      par_load(9);   // wraps to empty offset
      measure(ae, af);
      check("R6 wrap empty offset", ae, 9);
      check("R6 wrap full offset", af, 90);
      // strobe during partial reset is ignored
      @(negedge clk);
      prst_n = 1'b0; ld_stb = 1'b1; ld_data = 8'd77;
      @(negedge clk);
      prst_n = 1'b1; ld_stb = 1'b0;
      measure(ae, af);
      check("R9 partial reset keeps empty offset", ae, 9);
      check("R9 partial reset keeps full offset", af, 90);
   endtask

   task automatic t_serial();
      int ae, af;
      logic [15:0] word = {8'h81, 8'h2A};
      do_prst();
      ser_bit(1'b0, 1'b1);   // R8 ignored bits
      ser_bit(1'b0, 1'b1);
      for (int b = 0; b < 16; b++) ser_bit(1'b1, word[b]);
      for (int b = 0; b < 3; b++) ser_bit(1'b1, 1'b0);   // R7 extra bits dropped
      measure(ae, af);
      check("R7 R8 serial empty offset LSB first", ae, 8'h2A);
      check("R7 serial full offset", af, 8'h81);
      // partial pass: only low 4 bits of empty offset
      do_prst();
      for (int b = 0; b < 4; b++) ser_bit(1'b1, 1'b1);
      ser_bit(1'b0, 1'b0);
      measure(ae, af);
      check("R7 partial serial fill", ae, 8'h2F);
      check("R8 full offset untouched", af, 8'h81);
   endtask

   task automatic t_remaster();
      int ae, af;
      par_load(100);
      do_mrst(3'd0);
      measure(ae, af);
      check("R10 master reset sel0 empty", ae, 1);
      check("R10 master reset sel0 full", af, 1);
      do_mrst(3'd7);
      measure(ae, af);
      check("R1 preset sel7 empty", ae, 255);
      check("R1 preset sel7 full", af, 255);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      mrst_n = 1'b1;
      t_reset();
      t_count();
      t_sync_mode();
      t_parallel();
      t_serial();
      t_remaster();
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule